// File: doc/BRIEF.md
# Byte FIFO Pair with Fill-Level Interrupts

This block sits between a serial shift engine and a register bus. It keeps one byte queue for outgoing data and one for incoming data, each 64 entries deep. The bus side writes outgoing bytes and reads incoming ones. The shift engine does the opposite: it takes outgoing bytes and deposits received ones. Both queues return bytes in the order they were written.

Three pending flags drive a single level-sensitive interrupt line. The first means the receive queue is filling up, the second means the transmit queue is running low, and the third means the engine has finished a transfer. Software reads a packed occupancy word, masks the sources with an enable register, and acknowledges flags by writing ones to the pending register. A level flag whose condition still holds comes back one cycle after it is acknowledged, so draining or refilling the queue is what actually silences it.

Top module: `spi_fifo_irq`

## Requirements
- R1: Each direction is a 64-byte first-in first-out queue, and bytes leave in the order they were written.
- R2: A read at address 0 returns the receive occupancy (0..64) in bits 6:0 and the transmit occupancy in bits 22:16, with all other bits 0. A read at address 3 returns 0.
- R3: A write into a queue holding 64 bytes is ignored: the occupancy stays 64 and the stored bytes are unchanged.
- R4: A read from an empty queue is ignored and returns byte 0.
- R5: Pending bit 4 sets on the clock edge after the receive occupancy is 48 or more.
- R6: Pending bit 12 sets on the clock edge after the transmit occupancy is 16 or less.
- R7: Pending bit 16 sets on the edge after a one-cycle `xfer_done` pulse. A new pulse wins over an acknowledge of bit 16 in the same cycle.
- R8: The pending register is read at address 2. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. An acknowledged level flag whose condition still holds reads 0 for one cycle and then sets again.
- R9: The enable register at address 1 keeps only bits 4, 12 and 16, and all other bits read 0. Writing 0 masks every source.
- R10: `irq` is high exactly when some pending bit is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 occupancy, 1 enable, 2 pending |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_wr | input | 1 | Bus writes an outgoing byte |
| tx_wr_data | input | 8 | Outgoing byte |
| tx_rd | input | 1 | Shift engine takes an outgoing byte |
| tx_rd_data | output | 8 | Head of the outgoing queue, 0 when empty |
| rx_wr | input | 1 | Shift engine deposits a received byte |
| rx_wr_data | input | 8 | Received byte |
| rx_rd | input | 1 | Bus reads a received byte |
| rx_rd_data | output | 8 | Head of the incoming queue, 0 when empty |
| xfer_done | input | 1 | One-cycle transfer-complete pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The completion event and a software acknowledge of the same flag can fall in one cycle. The bench provokes this by raising `xfer_done` in the same cycle as a write of bit 16 to the pending register, and it expects bit 16 to read 1 afterwards. A second, separate acknowledge must then clear it. The level flags have a similar race between acknowledge and condition. The bench clears bit 12 while the transmit queue is empty and checks that the bit reads 0 for one cycle and 1 on the next.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int RX_HI_BIT = 4;
  localparam int TX_LO_BIT = 12;
  localparam int DONE_BIT  = 16;
  localparam int RXCNT_LSB = 0;
  localparam int TXCNT_LSB = 16;

  localparam logic [1:0] A_LEVEL   = 2'd0;
  localparam logic [1:0] A_ENABLE  = 2'd1;
  localparam logic [1:0] A_PENDING = 2'd2;

  localparam logic [31:0] SRC_MASK =
    (32'd1 << RX_HI_BIT) | (32'd1 << TX_LO_BIT) | (32'd1 << DONE_BIT);

  function automatic int fill_mark(int depth);
    return (depth * 3) / 4;
  endfunction

  function automatic int drain_mark(int depth);
    return depth / 4;
  endfunction

  function automatic logic at_least(int cnt, int mark);
    return cnt >= mark;
  endfunction

  function automatic logic at_most(int cnt, int mark);
    return cnt <= mark;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign pop_data = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: occupancy is bounded and a refused write leaves it unchanged
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CW'(DEPTH)));
  // R4: a read of an empty queue does not move it
  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/irq_status.sv
module irq_status
  import fifo_irq_pkg::*;
#(
  parameter int CW    = 7,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic          done_evt,
  input  logic          en_we,
  input  logic          pend_we,
  input  logic [31:0]   wdata,
  output logic [31:0]   en_q,
  output logic [31:0]   pend_q,
  output logic          irq
);
  localparam int RX_MARK = fill_mark(DEPTH);
  localparam int TX_MARK = drain_mark(DEPTH);

  logic        rx_hi, tx_lo;
  logic        p_rx, p_tx, p_done;
  logic [31:0] clr;

  assign rx_hi = at_least(int'(rx_cnt), RX_MARK);
  assign tx_lo = at_most(int'(tx_cnt), TX_MARK);
  assign clr   = pend_we ? (wdata & SRC_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rx   <= 1'b0;
      p_tx   <= 1'b0;
      p_done <= 1'b0;
      en_q   <= '0;
    end else begin
      if (clr[RX_HI_BIT])      p_rx <= 1'b0;
      else if (rx_hi)          p_rx <= 1'b1;
      if (clr[TX_LO_BIT])      p_tx <= 1'b0;
      else if (tx_lo)          p_tx <= 1'b1;
      if (done_evt)            p_done <= 1'b1;
      else if (clr[DONE_BIT])  p_done <= 1'b0;
      if (en_we)               en_q <= wdata & SRC_MASK;
    end
  end

  always_comb begin
    pend_q = '0;
    pend_q[RX_HI_BIT] = p_rx;
    pend_q[TX_LO_BIT] = p_tx;
    pend_q[DONE_BIT]  = p_done;
  end

  assign irq = |(pend_q & en_q);

  // R5: an unmasked, unacknowledged fill condition latches
  assert_rx_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hi && !clr[RX_HI_BIT]) |=> p_rx);
  // R7: completion wins over a simultaneous acknowledge
  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> p_done);
  // R8: acknowledge clears for one cycle even with the condition present
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr[TX_LO_BIT] |=> !p_tx);
  // R9: only the three source bits can be enabled
  assert_en_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~SRC_MASK) == '0);
  // R10: nothing enabled means no request
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_we,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_wr_data,
  input  logic         tx_rd,
  output logic [W-1:0] tx_rd_data,
  input  logic         rx_wr,
  input  logic [W-1:0] rx_wr_data,
  input  logic         rx_rd,
  output logic [W-1:0] rx_rd_data,
  input  logic         xfer_done,
  output logic         irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [31:0]   en_q, pend_q, level_word;
  logic          en_we, pend_we;

  byte_fifo #(.DEPTH(DEPTH), .W(W)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr), .push_data(tx_wr_data),
    .pop(tx_rd), .pop_data(tx_rd_data), .count(tx_cnt));

  byte_fifo #(.DEPTH(DEPTH), .W(W)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_wr), .push_data(rx_wr_data),
    .pop(rx_rd), .pop_data(rx_rd_data), .count(rx_cnt));

  assign en_we   = reg_we && (reg_addr == A_ENABLE);
  assign pend_we = reg_we && (reg_addr == A_PENDING);

  irq_status #(.CW(CW), .DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .done_evt(xfer_done),
    .en_we(en_we), .pend_we(pend_we), .wdata(reg_wdata),
    .en_q(en_q), .pend_q(pend_q), .irq(irq));

  always_comb begin
    level_word = '0;
    level_word[RXCNT_LSB +: CW] = rx_cnt;
    level_word[TXCNT_LSB +: CW] = tx_cnt;
  end

  always_comb begin
    case (reg_addr)
      A_LEVEL:   reg_rdata = level_word;
      A_ENABLE:  reg_rdata = en_q;
      A_PENDING: reg_rdata = pend_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/sim_spi_fifo_irq.sv
module sim_spi_fifo_irq;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        tx_wr = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0, xfer_done = 0, irq;
  logic [7:0]  tx_wr_data = 0, rx_wr_data = 0, tx_rd_data, rx_rd_data;
  int total = 0, bad = 0;
  logic [7:0] txq[$], rxq[$];
  logic [31:0] v;

  always #5 clk = ~clk;

  spi_fifo_irq u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare each queue head taken against the model
  always @(negedge clk) begin
    if (rst_n && tx_rd) chk("R1/R4 tx order", {24'd0, tx_rd_data},
                            {24'd0, (txq.size() > 0) ? txq.pop_front() : 8'd0});
    if (rst_n && rx_rd) chk("R1/R4 rx order", {24'd0, rx_rd_data},
                            {24'd0, (rxq.size() > 0) ? rxq.pop_front() : 8'd0});
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic put_tx(logic [7:0] b);
    tx_wr = 1; tx_wr_data = b;
    if (txq.size() < 64) txq.push_back(b);
    step(); tx_wr = 0;
  endtask
  task automatic put_rx(logic [7:0] b);
    rx_wr = 1; rx_wr_data = b;
    if (rxq.size() < 64) rxq.push_back(b);
    step(); rx_wr = 0;
  endtask
  task automatic take_tx(); tx_rd = 1; step(); tx_rd = 0; endtask
  task automatic take_rx(); rx_rd = 1; step(); rx_rd = 0; endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1; step(); reg_we = 0;
  endtask
  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2;
    rd(2'd0, v); chk("R2 reset occupancy", v, 0);
    rd(2'd2, v); chk("R8 reset pending", v, 0);
    chk("R10 reset irq", {31'd0, irq}, 0);
    step(); rst_n = 1; step();
    rd(2'd2, v); chk("R6 tx low after reset", v, 32'h1000);
    chk("R9 irq masked at reset", {31'd0, irq}, 0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R9 enable keeps three bits", v, 32'h0001_1010);
    chk("R10 irq with tx flag enabled", {31'd0, irq}, 1);
    rd(2'd3, v); chk("R2 unused address", v, 0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R8 ack clears for a cycle", v, 0);
    step();
    rd(2'd2, v); chk("R8 level flag returns", v, 32'h1000);
    for (int i = 0; i < 65; i++) put_tx(8'(i * 7 + 3));
    rd(2'd0, v); chk("R3 tx full stays 64", v, 32'h0040_0000);
    wr(2'd2, 32'h1000); step();
    rd(2'd2, v); chk("R8 ack sticks when condition gone", v, 0);
    chk("R10 irq low with nothing pending", {31'd0, irq}, 0);
    for (int i = 0; i < 65; i++) take_tx();
    rd(2'd0, v); chk("R4 tx empty after extra read", v, 0);
    for (int i = 0; i < 47; i++) put_rx(8'hA5 ^ 8'(i));
    step();
    rd(2'd2, v); chk("R5 rx flag clear at 47", v & 32'h10, 0);
    put_rx(8'h5A); step();
    rd(2'd2, v); chk("R5 rx flag set at 48", v & 32'h10, 32'h10);
    chk("R10 irq from rx flag", {31'd0, irq}, 1);
    for (int i = 0; i < 17; i++) put_rx(8'(i * 13));
    rd(2'd0, v); chk("R2/R3 rx full count", v, 32'd64);
    for (int i = 0; i < 65; i++) take_rx();
    wr(2'd2, 32'h10); step();
    rd(2'd2, v); chk("R5 rx flag gone when drained", v & 32'h10, 0);
    xfer_done = 1; step(); xfer_done = 0;
    rd(2'd2, v); chk("R7 done sets", v & 32'h1_0000, 32'h1_0000);
    xfer_done = 1; wr(2'd2, 32'h1_0000); xfer_done = 0;
    rd(2'd2, v); chk("R7 done wins over ack", v & 32'h1_0000, 32'h1_0000);
    wr(2'd2, 32'h1_0000);
    rd(2'd2, v); chk("R7 ack alone clears done", v & 32'h1_0000, 0);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R8 writing zero keeps flags", v, 32'h1000);
    wr(2'd1, 32'h0);
    chk("R9 disable all drops irq", {31'd0, irq}, 0);
    wr(2'd1, 32'h1_0000);
    chk("R10 tx flag not enabled", {31'd0, irq}, 0);
    xfer_done = 1; step(); xfer_done = 0;
    chk("R10 irq from done only", {31'd0, irq}, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule